// File: doc/BRIEF.md
# Serial Port Interrupt Flag Controller

This block keeps the status flags of an asynchronous serial port and produces its three interrupt requests: receive, transmit and bus idle. The receive and transmit datapaths send it single-cycle event pulses and two activity levels. The register file sends it read and write strobes for the receive data, transmit data, control and extended interrupt registers. Software reads the flags back through three 8-bit readback buses.

Each flag that software acknowledges exists in two forms. One is a status flag that clears itself when its cause goes away or when data is read. The other is a sticky copy that stays set until software writes 0 to it. A mode bit in the control register chooses which form drives the receive and bus-idle interrupts, so an interrupt handler can acknowledge a request without racing the hardware. The error flags are cleared together by a clear bit in the control register. This bit is write-only and acts as a one-cycle pulse.

Top module: `sio_irq_flags`

## Requirements
- R1: An `evRxDone` pulse sets the ready flag (statRd[0]) and the extended ready flag (extRd[0]) on the same clock edge.
- R2: If `evRxDone` arrives while statRd[0] is 1 and `rdRxData` is not asserted in that cycle, the overrun flag (statRd[1]) is set.
- R3: `evStopErr` sets the framing flag (statRd[2]) and `evParErr` sets the parity flag (statRd[3]). Each flag holds until it is cleared.
- R4: statRd[0] is cleared only by `rdRxData`. If `rdRxData` and `evRxDone` occur in the same cycle, statRd[0] stays 1 and no overrun is flagged.
- R5: A control write (`wrCtrl`) with wrData[0]=1 produces an internal pulse one cycle long. The pulse clears statRd[1..3] on the second clock edge after the write. ctrlRd[0] always reads 0.
- R6: An extended write (`wrExt`) with wrData[0]=0 clears extRd[0]; writing 1 to that bit has no effect. An `evRxDone` in the same cycle takes priority, and the flag stays 1.
- R7: The transmit-empty flag (statRd[4]) resets to 1. `evTxLoad` sets it and `wrTxData` clears it. If both occur in the same cycle, the write wins.
- R8: The registered output `irqTx` equals txIe (ctrlRd[2]) AND statRd[4] at every edge, so it rises right after txIe is written as 1 following reset.
- R9: The registered output `irqRx` equals rxIe (ctrlRd[1]) AND (ready OR statRd[1] OR statRd[2] OR statRd[3]). Ready means statRd[0] when mode (ctrlRd[4]) is 0 and extRd[0] when mode is 1.
- R10: The receive-idle level flag (statRd[5]) and the transmit-idle flag (statRd[6]) show the inverse of `rxActive` and `txActive`, delayed by one register.
- R11: The sticky receive-idle flag (extRd[1]) is set on the edge where statRd[5] goes from 0 to 1. It holds until an extended write with wrData[1]=0, and the set event wins over the write.
- R12: The registered output `irqIdle` equals bus-idle enable (ctrlRd[3]) AND statRd[6] AND the receive-idle flag. That flag is statRd[5] in mode 0 and extRd[1] in mode 1. The output drops on the same edge as either of its input flags.
- R13: After reset, statRd = 8'h70, extRd = 8'h02, ctrlRd = 8'h00 and all three interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evRxDone | input | 1 | Pulse: received word moved into the receive data register |
| evStopErr | input | 1 | Pulse: a 0 was sampled where the stop bit belongs |
| evParErr | input | 1 | Pulse: the received parity bit was wrong |
| evTxLoad | input | 1 | Pulse: transmit data moved into the shift register |
| rxActive | input | 1 | Level: a reception is in progress |
| txActive | input | 1 | Level: a transmission is in progress |
| rdRxData | input | 1 | Read strobe of the receive data register |
| wrTxData | input | 1 | Write strobe of the transmit data register |
| wrCtrl | input | 1 | Write strobe of the control register |
| wrExt | input | 1 | Write strobe of the extended interrupt register |
| wrData | input | REG_W | Write data shared by both register writes |
| ctrlRd | output | REG_W | Control readback: [0] clear (reads 0), [1] rxIe, [2] txIe, [3] idleIe, [4] mode |
| statRd | output | REG_W | Status: [0] ready, [1] overrun, [2] framing, [3] parity, [4] tx empty, [5] rx idle, [6] tx idle |
| extRd | output | REG_W | Extended: [0] sticky ready, [1] sticky rx idle |
| irqRx | output | 1 | Receive interrupt request |
| irqTx | output | 1 | Transmit interrupt request |
| irqIdle | output | 1 | Bus-idle interrupt request |

## Verification
The properties assume that the event inputs and strobes are synchronous to `clk` and stable around the sampling edge. The error-clear property also assumes that no error or receive event arrives in the cycle after the clear write, because such an event would legitimately set a flag again. The bench drives every input on the falling edge, holds each strobe for exactly one cycle and keeps events apart from the clear sequence unless a test deliberately makes them collide. Tests that collide a set with a clear do so only for flags whose set-wins rule is a requirement.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  // control register bit positions
  localparam int CTRL_CLR  = 0;
  localparam int CTRL_RIE  = 1;
  localparam int CTRL_TIE  = 2;
  localparam int CTRL_BIE  = 3;
  localparam int CTRL_MODE = 4;
  // extended register bit positions
  localparam int EXT_RDY   = 0;
  localparam int EXT_IDLE  = 1;

  typedef struct packed {
    logic mode;
    logic idleIe;
    logic txIe;
    logic rxIe;
  } cfg_t;

  typedef struct packed {
    logic clrErr;
    logic ackExtRdy;
    logic ackRxIdle;
    logic rdRx;
    logic wrTx;
    logic ldCfg;
    cfg_t cfg;
  } strobe_t;

  typedef struct packed {
    logic rdy;
    logic ovr;
    logic frm;
    logic par;
    logic txEmpty;
    logic rxIdleLvl;
    logic txIdle;
    logic extRdy;
    logic rxIdleSticky;
  } flag_t;

endpackage

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdRxData,
  input  logic             wrTxData,
  input  logic             wrCtrl,
  input  logic             wrExt,
  input  logic [REG_W-1:0] wrData,
  output strobe_t          strobes
);

  logic clrPulse;

  // write-one clear bit becomes a one-cycle internal pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrPulse <= 1'b0;
    else       clrPulse <= wrCtrl & wrData[CTRL_CLR];
  end

  always_comb begin
    strobes.clrErr      = clrPulse;
    strobes.ackExtRdy   = wrExt & ~wrData[EXT_RDY];
    strobes.ackRxIdle   = wrExt & ~wrData[EXT_IDLE];
    strobes.rdRx        = rdRxData;
    strobes.wrTx        = wrTxData;
    strobes.ldCfg       = wrCtrl;
    strobes.cfg.mode    = wrData[CTRL_MODE];
    strobes.cfg.idleIe  = wrData[CTRL_BIE];
    strobes.cfg.txIe    = wrData[CTRL_TIE];
    strobes.cfg.rxIe    = wrData[CTRL_RIE];
  end

endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  logic    evRxDone,
  input  logic    evStopErr,
  input  logic    evParErr,
  input  logic    evTxLoad,
  input  logic    rxActive,
  input  logic    txActive,
  output flag_t   flags,
  output cfg_t    cfg,
  output logic    irqRx,
  output logic    irqTx,
  output logic    irqIdle
);

  flag_t flagsNxt;
  cfg_t  cfgNxt;
  logic  rdySel, idleSel;

  always_comb begin
    cfgNxt = strobes.ldCfg ? strobes.cfg : cfg;

    flagsNxt.rdy  = evRxDone | (flags.rdy & ~strobes.rdRx);
    flagsNxt.ovr  = (evRxDone & flags.rdy & ~strobes.rdRx) | (flags.ovr & ~strobes.clrErr);
    flagsNxt.frm  = evStopErr | (flags.frm & ~strobes.clrErr);
    flagsNxt.par  = evParErr  | (flags.par & ~strobes.clrErr);

    // a data write in the same cycle as a load leaves the register full
    flagsNxt.txEmpty = ~strobes.wrTx & (evTxLoad | flags.txEmpty);

    flagsNxt.rxIdleLvl    = ~rxActive;
    flagsNxt.txIdle       = ~txActive;
    flagsNxt.extRdy       = evRxDone | (flags.extRdy & ~strobes.ackExtRdy);
    flagsNxt.rxIdleSticky = (~rxActive & ~flags.rxIdleLvl)
                          | (flags.rxIdleSticky & ~strobes.ackRxIdle);

    rdySel  = cfgNxt.mode ? flagsNxt.extRdy : flagsNxt.rdy;
    idleSel = cfgNxt.mode ? flagsNxt.rxIdleSticky : flagsNxt.rxIdleLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      flags   <= '{rdy: 1'b0, ovr: 1'b0, frm: 1'b0, par: 1'b0, txEmpty: 1'b1,
                   rxIdleLvl: 1'b1, txIdle: 1'b1, extRdy: 1'b0, rxIdleSticky: 1'b1};
      irqRx   <= 1'b0;
      irqTx   <= 1'b0;
      irqIdle <= 1'b0;
    end else begin
      cfg     <= cfgNxt;
      flags   <= flagsNxt;
      irqRx   <= cfgNxt.rxIe & (rdySel | flagsNxt.ovr | flagsNxt.frm | flagsNxt.par);
      irqTx   <= cfgNxt.txIe & flagsNxt.txEmpty;
      irqIdle <= cfgNxt.idleIe & flagsNxt.txIdle & idleSel;
    end
  end

endmodule

// File: rtl/sio_irq_flags.sv
module sio_irq_flags
  import sio_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evRxDone,
  input  logic             evStopErr,
  input  logic             evParErr,
  input  logic             evTxLoad,
  input  logic             rxActive,
  input  logic             txActive,
  input  logic             rdRxData,
  input  logic             wrTxData,
  input  logic             wrCtrl,
  input  logic             wrExt,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlRd,
  output logic [REG_W-1:0] statRd,
  output logic [REG_W-1:0] extRd,
  output logic             irqRx,
  output logic             irqTx,
  output logic             irqIdle
);

  strobe_t strobes;
  flag_t   flags;
  cfg_t    cfg;

  sio_irq_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdRxData(rdRxData), .wrTxData(wrTxData),
    .wrCtrl(wrCtrl), .wrExt(wrExt), .wrData(wrData), .strobes(strobes)
  );

  sio_irq_regs u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evRxDone(evRxDone),
    .evStopErr(evStopErr), .evParErr(evParErr), .evTxLoad(evTxLoad),
    .rxActive(rxActive), .txActive(txActive), .flags(flags), .cfg(cfg),
    .irqRx(irqRx), .irqTx(irqTx), .irqIdle(irqIdle)
  );

  always_comb begin
    ctrlRd = '0;
    ctrlRd[CTRL_RIE]  = cfg.rxIe;
    ctrlRd[CTRL_TIE]  = cfg.txIe;
    ctrlRd[CTRL_BIE]  = cfg.idleIe;
    ctrlRd[CTRL_MODE] = cfg.mode;

    statRd = '0;
    statRd[0] = flags.rdy;
    statRd[1] = flags.ovr;
    statRd[2] = flags.frm;
    statRd[3] = flags.par;
    statRd[4] = flags.txEmpty;
    statRd[5] = flags.rxIdleLvl;
    statRd[6] = flags.txIdle;

    extRd = '0;
    extRd[EXT_RDY]  = flags.extRdy;
    extRd[EXT_IDLE] = flags.rxIdleSticky;
  end

endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             evRxDone,
  input logic             evStopErr,
  input logic             evParErr,
  input logic             evTxLoad,
  input logic             rdRxData,
  input logic             wrTxData,
  input logic             wrCtrl,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] ctrlRd,
  input logic [REG_W-1:0] statRd,
  input logic [REG_W-1:0] extRd,
  input logic             irqRx,
  input logic             irqTx,
  input logic             irqIdle
);

  AST_RDY_SET: assert property (@(posedge clk) disable iff (!rstN) evRxDone |=> statRd[0] && extRd[0]); // R1
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN) evRxDone && statRd[0] && !rdRxData |=> statRd[1]); // R2
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN) evStopErr && evParErr |=> statRd[2] && statRd[3]); // R3
  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rstN) statRd[0] && !rdRxData |=> statRd[0]); // R4
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rstN) (wrCtrl && wrData[0]) ##1 (!evStopErr && !evParErr && !evRxDone) |=> (statRd[3:1] == 3'b000)); // R5
  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rstN) evTxLoad && !wrTxData |=> statRd[4]); // R7
  AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rstN) irqTx == (ctrlRd[2] && statRd[4])); // R8
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (!rstN) irqRx == (ctrlRd[1] && (statRd[1] || statRd[2] || statRd[3] || (ctrlRd[4] ? extRd[0] : statRd[0])))); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN) irqIdle == (ctrlRd[3] && statRd[6] && (ctrlRd[4] ? extRd[1] : statRd[5]))); // R12

endmodule

bind sio_irq_flags sio_irq_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .evRxDone(evRxDone), .evStopErr(evStopErr),
  .evParErr(evParErr), .evTxLoad(evTxLoad), .rdRxData(rdRxData),
  .wrTxData(wrTxData), .wrCtrl(wrCtrl), .wrData(wrData), .ctrlRd(ctrlRd),
  .statRd(statRd), .extRd(extRd), .irqRx(irqRx), .irqTx(irqTx), .irqIdle(irqIdle)
);

// File: tb/test_sio_irq_flags.sv
module test_sio_irq_flags;

  localparam int REG_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evRxDone = 0, evStopErr = 0, evParErr = 0, evTxLoad = 0;
  logic rxActive = 0, txActive = 0;
  logic rdRxData = 0, wrTxData = 0, wrCtrl = 0, wrExt = 0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] ctrlRd, statRd, extRd;
  logic irqRx, irqTx, irqIdle;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sio_irq_flags #(.REG_W(REG_W)) i_sio_irq_flags (
    .clk(clk), .rstN(rstN), .evRxDone(evRxDone), .evStopErr(evStopErr),
    .evParErr(evParErr), .evTxLoad(evTxLoad), .rxActive(rxActive),
    .txActive(txActive), .rdRxData(rdRxData), .wrTxData(wrTxData),
    .wrCtrl(wrCtrl), .wrExt(wrExt), .wrData(wrData), .ctrlRd(ctrlRd),
    .statRd(statRd), .extRd(extRd), .irqRx(irqRx), .irqTx(irqTx), .irqIdle(irqIdle)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {evRxDone, evStopErr, evParErr, evTxLoad, rxActive, txActive} = '0;
    {rdRxData, wrTxData, wrCtrl, wrExt} = '0;
    wrData = '0;
    repeat (2) cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic writeCtrl(input logic [REG_W-1:0] d);
    wrCtrl = 1'b1; wrData = d; cyc(); wrCtrl = 1'b0; wrData = '0;
  endtask

  task automatic writeExt(input logic [REG_W-1:0] d);
    wrExt = 1'b1; wrData = d; cyc(); wrExt = 1'b0; wrData = '0;
  endtask

  task automatic rxDone();
    evRxDone = 1'b1; cyc(); evRxDone = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R13 statRd", statRd, 8'h70);
    check("R13 extRd", extRd, 8'h02);
    check("R13 ctrlRd", ctrlRd, 8'h00);
    check("R13 irqs", {irqRx, irqTx, irqIdle}, 3'b000);
  endtask

  task automatic testReceive();
    doReset();
    rxDone();
    check("R1 ready", statRd[0], 1'b1);
    check("R1 ext ready", extRd[0], 1'b1);
    check("R4 ready holds without read", statRd[0], 1'b1);
    rxDone();
    check("R2 overrun", statRd[1], 1'b1);
    rdRxData = 1'b1; cyc(); rdRxData = 1'b0;
    check("R4 read clears ready", statRd[0], 1'b0);
    // clear overrun, then collide a read with a completion
    writeCtrl(8'h01); cyc();
    rxDone();
    evRxDone = 1'b1; rdRxData = 1'b1; cyc(); evRxDone = 1'b0; rdRxData = 1'b0;
    check("R4 read+done keeps ready", statRd[0], 1'b1);
    check("R4 read+done no overrun", statRd[1], 1'b0);
  endtask

  task automatic testErrors();
    doReset();
    writeCtrl(8'h02);
    evStopErr = 1'b1; cyc(); evStopErr = 1'b0;
    check("R3 framing", statRd[2], 1'b1);
    check("R9 irqRx on framing", irqRx, 1'b1);
    evParErr = 1'b1; cyc(); evParErr = 1'b0;
    check("R3 parity", statRd[3], 1'b1);
    rxDone(); rxDone();
    check("R2 overrun before clear", statRd[1], 1'b1);
    writeCtrl(8'h03);
    check("R5 errors held one cycle", statRd[3:1], 3'b111);
    check("R5 clear bit reads 0", ctrlRd[0], 1'b0);
    cyc();
    check("R5 errors cleared", statRd[3:1], 3'b000);
    check("R5 ready untouched", statRd[0], 1'b1);
    rdRxData = 1'b1; cyc(); rdRxData = 1'b0;
    check("R9 irqRx drops", irqRx, 1'b0);
  endtask

  task automatic testRxIrqModes();
    doReset();
    writeCtrl(8'h02); // rxIe, mode 0
    rxDone();
    check("R9 mode0 irq", irqRx, 1'b1);
    writeExt(8'h02);
    check("R6 ext ready cleared", extRd[0], 1'b0);
    check("R9 mode0 ignores ext", irqRx, 1'b1);
    rdRxData = 1'b1; cyc(); rdRxData = 1'b0;
    check("R9 mode0 irq off", irqRx, 1'b0);

    doReset();
    writeCtrl(8'h12); // rxIe, mode 1
    rxDone();
    rdRxData = 1'b1; cyc(); rdRxData = 1'b0;
    check("R9 mode1 irq held by ext", irqRx, 1'b1);
    writeExt(8'h03);
    check("R6 write 1 no effect", extRd[0], 1'b1);
    evRxDone = 1'b1; wrExt = 1'b1; wrData = 8'h02; cyc();
    evRxDone = 1'b0; wrExt = 1'b0; wrData = '0;
    check("R6 done wins over ack", extRd[0], 1'b1);
    rdRxData = 1'b1; cyc(); rdRxData = 1'b0;
    writeExt(8'h02);
    check("R9 mode1 irq off", irqRx, 1'b0);
  endtask

  task automatic testTransmit();
    doReset();
    writeCtrl(8'h04);
    check("R8 irqTx after enable", irqTx, 1'b1);
    wrTxData = 1'b1; cyc(); wrTxData = 1'b0;
    check("R7 write clears empty", statRd[4], 1'b0);
    check("R8 irqTx off", irqTx, 1'b0);
    evTxLoad = 1'b1; cyc(); evTxLoad = 1'b0;
    check("R7 load sets empty", statRd[4], 1'b1);
    check("R8 irqTx on", irqTx, 1'b1);
    evTxLoad = 1'b1; wrTxData = 1'b1; cyc(); evTxLoad = 1'b0; wrTxData = 1'b0;
    check("R7 write wins", statRd[4], 1'b0);
  endtask

  task automatic testIdle();
    doReset();
    writeCtrl(8'h08); // idleIe, mode 0
    check("R12 idle irq mode0", irqIdle, 1'b1);
    rxActive = 1'b1; cyc();
    check("R10 rx idle clears", statRd[5], 1'b0);
    check("R12 idle irq drops", irqIdle, 1'b0);
    check("R11 sticky holds", extRd[1], 1'b1);
    writeExt(8'h01);
    check("R11 sticky acked", extRd[1], 1'b0);
    rxActive = 1'b0; cyc();
    check("R10 rx idle back", statRd[5], 1'b1);
    check("R11 sticky set at idle start", extRd[1], 1'b1);
    writeCtrl(8'h18); // mode 1
    check("R12 mode1 on", irqIdle, 1'b1);
    writeExt(8'h01);
    check("R12 mode1 follows sticky", irqIdle, 1'b0);
    check("R10 level still idle", statRd[5], 1'b1);
    writeCtrl(8'h08);
    check("R12 mode0 again", irqIdle, 1'b1);
    txActive = 1'b1; cyc();
    check("R10 tx idle clears", statRd[6], 1'b0);
    check("R12 drops on tx", irqIdle, 1'b0);
    txActive = 1'b0; cyc();
    check("R10 tx idle back", statRd[6], 1'b1);
  endtask

  logic finished = 1'b0;

  initial begin
    testReset();
    testReceive();
    testErrors();
    testRxIrqModes();
    testTransmit();
    testIdle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule